// File: doc/BRIEF.md
# Two-Wire Target Real-Time Clock

This block is a target device on a two-wire (I2C) bus that keeps a running time of day in a sixteen-byte register file. It takes the serial clock and data lines from the bus and synchronises them. It finds START and STOP conditions and answers a 7-bit device address. That address is made of a fixed `1010` prefix and three strap pins, so up to eight of these devices can share one bus. The block only ever pulls SDA low, through an output-enable. Driving the line is left to the pad.

A write transfer first loads a register pointer and then fills registers from that pointer onward. A read transfer streams registers out from the pointer until the controller declines a byte. A single-cycle tick input, normally one pulse per second, advances seconds, minutes and hours. These are held in BCD unless a halt bit is set. Each counted tick also raises an event flag, and an interrupt output shows that flag when it is enabled.

Top module: `rtc_i2c_top`

## Requirements
- R1: A START (SDA falling while SCL is high) sends the device back to receiving an address byte, including a repeated START in the middle of a transfer. A STOP (SDA rising while SCL is high) returns it to idle.
- R2: The first byte after START is matched when bits 7..4 are `1010` and bits 3..1 equal `dev_sel`. Bit 0 is the direction: 0 means write and 1 means read. On a match, SDA is pulled low for the ninth clock. With `dev_sel`=001 the write byte is 0xA2 and the read byte is 0xA3.
- R3: After an address that does not match, `sda_oe` stays 0 and no register changes until the next START or STOP.
- R4: `sda_oe` changes only while SCL is low. Read data goes out MSB first.
- R5: In a write, the first data byte loads the pointer from its low four bits. Each later byte is stored at the pointer. Every byte is acknowledged.
- R6: The pointer increments after every stored or sent byte and wraps from 0Fh to 00h.
- R7: A read sends the byte at the pointer. It sends the next byte after a controller ACK (SDA low on the ninth clock) and releases SDA after a NACK.
- R8: Seconds (02h, 00–59), minutes (03h, 00–59) and hours (04h, 00–23) are BCD. Each tick advances seconds, carries into minutes and hours, and wraps 23:59:59 to 00:00:00.
- R9: Bit 5 of register 00h is a halt bit. While it is 1, ticks leave the time unchanged.
- R10: In register 01h, bit 0 is the interrupt enable and bit 1 is an event flag. The flag is set on every counted tick and cleared by writing it as 0. `irq` is high exactly when both bits are 1.
- R11: After reset all registers are 00h, the pointer is 00h, `sda_oe` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_sel | input | 3 | Strap pins that give the low three address bits |
| sec_tick | input | 1 | Single-cycle time-advance pulse |
| irq | output | 1 | Interrupt, high while enabled and flagged |

## Verification
The bench uses the default two-stage line synchroniser and a sixteen-entry register file, with the strap pins set to 001. At that file size a transfer of seventeen bytes is enough to reach the pointer wrap, for both reads and writes. With the short synchroniser, a bit period of sixteen system clocks still leaves a margin of several clocks between the design driving SDA and the controller sampling it. Foreign addresses that differ in the strap bits and in the fixed prefix show that the device stays silent. Preloading 23:59:58 and 09 seconds brings the hour rollover and the BCD digit carry into reach within a few ticks.

// File: rtl/rtc_i2c_pkg.sv
// Shared constants, types and helpers for the two-wire RTC target.
// Assumes an 8-bit register byte and the fixed register layout below.
package rtc_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    // Register layout: control first, then the time bytes.
    localparam int A_CTRL1 = 0;
    localparam int A_CTRL2 = 1;
    localparam int A_SEC   = 2;
    localparam int A_MIN   = 3;
    localparam int A_HR    = 4;

    localparam int HALT_BIT = 5;
    localparam int IEN_BIT  = 0;
    localparam int FLAG_BIT = 1;

    typedef enum logic [2:0] {
        LS_IDLE, LS_ADDR, LS_ACK, LS_WRITE, LS_READ, LS_RACK, LS_IGNORE
    } link_state_t;

    // Adds one to a two-digit BCD value. The caller handles the wrap.
    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction
endpackage

// File: rtl/rtc_line_sync.sv
// Synchronises SCL and SDA and reports edge and bus-condition events.
// Assumes SCL is much slower than clk. The bus idles high after reset.
module rtc_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] scl_q;
    logic [LAST:0] sda_q;

    // Shift both lines through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[LAST-1:0], scl_i};
            sda_q <= {sda_q[LAST-1:0], sda_i};
        end
    end

    // Decode edges and conditions from the current and previous samples.
    always_comb begin
        scl_s    = scl_q[LAST-1];
        sda_s    = sda_q[LAST-1];
        scl_rise = scl_q[LAST-1] & ~scl_q[LAST];
        scl_fall = ~scl_q[LAST-1] & scl_q[LAST];
        start_ev = scl_q[LAST-1] & scl_q[LAST] & ~sda_q[LAST-1] & sda_q[LAST];
        stop_ev  = scl_q[LAST-1] & scl_q[LAST] & sda_q[LAST-1] & ~sda_q[LAST];
    end
endmodule

// File: rtl/rtc_bus_link.sv
// Bit and byte engine of the target: address match, acknowledge,
// byte delivery on writes and byte fetch on reads. It only drives SDA
// low, and only changes that drive after a falling SCL edge.
module rtc_bus_link
    import rtc_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [2:0]        dev_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic              wr_first,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req
);
    link_state_t       state;
    logic [2:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              phase;
    logic              got_ack;
    logic              first_byte;
    logic [BYTE_W-1:0] rx_byte;

    // Byte being completed on this rising edge.
    always_comb rx_byte = {shreg[BYTE_W-2:0], sda_s};

    // Protocol sequencer: a START or STOP overrides every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= LS_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            tx         <= '0;
            rw         <= 1'b0;
            phase      <= 1'b0;
            got_ack    <= 1'b0;
            first_byte <= 1'b0;
            sda_oe     <= 1'b0;
            wr_valid   <= 1'b0;
            wr_first   <= 1'b0;
            wr_data    <= '0;
            rd_req     <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            rd_req   <= 1'b0;
            if (start_ev) begin
                state  <= LS_ADDR;
                cnt    <= '0;
                phase  <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                state  <= LS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    LS_ADDR: if (scl_rise) begin
                        shreg <= rx_byte;
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            rw         <= sda_s;
                            phase      <= 1'b0;
                            first_byte <= 1'b1;
                            state      <= (rx_byte[7:1] == {DEV_PREFIX, dev_sel}) ? LS_ACK : LS_IGNORE;
                        end
                    end
                    LS_ACK: if (scl_fall) begin
                        if (!phase) begin
                            sda_oe <= 1'b1;
                            phase  <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            cnt   <= '0;
                            if (rw) begin
                                rd_req <= 1'b1;
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= LS_READ;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= LS_WRITE;
                            end
                        end
                    end
                    LS_WRITE: if (scl_rise) begin
                        shreg <= rx_byte;
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            wr_valid   <= 1'b1;
                            wr_data    <= rx_byte;
                            wr_first   <= first_byte;
                            first_byte <= 1'b0;
                            phase      <= 1'b0;
                            state      <= LS_ACK;
                        end
                    end
                    LS_READ: begin
                        if (scl_rise) begin
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) begin
                                phase <= 1'b0;
                                state <= LS_RACK;
                            end
                        end else if (scl_fall) begin
                            sda_oe <= ~tx[BYTE_W-2];
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                    LS_RACK: begin
                        if (scl_rise && phase) begin
                            got_ack <= ~sda_s;
                        end else if (scl_fall && !phase) begin
                            sda_oe <= 1'b0;
                            phase  <= 1'b1;
                        end else if (scl_fall) begin
                            phase <= 1'b0;
                            cnt   <= '0;
                            if (got_ack) begin
                                rd_req <= 1'b1;
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= LS_READ;
                            end else begin
                                state <= LS_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4
    sda_low_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_IGNORE) |-> !sda_oe);
    // R5
    wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_req));
endmodule

// File: rtl/rtc_time_regs.sv
// Register file with pointer, BCD timekeeping, halt and interrupt flag.
// Assumes time bytes hold valid BCD. A bus write wins over a tick to
// the same byte in the same cycle.
module rtc_time_regs
    import rtc_i2c_pkg::*;
#(
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_first,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              sec_tick,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq
);
    localparam int NREG = 1 << REG_AW;

    logic [BYTE_W-1:0] regs [NREG];
    logic [REG_AW-1:0] ptr;
    logic              run_tick;
    logic              sec_wrap;
    logic              min_wrap;
    logic              hr_wrap;

    // Time carry conditions and read data.
    always_comb begin
        run_tick = sec_tick & ~regs[A_CTRL1][HALT_BIT];
        sec_wrap = regs[A_SEC] == 8'h59;
        min_wrap = regs[A_MIN] == 8'h59;
        hr_wrap  = regs[A_HR]  == 8'h23;
        rd_data  = regs[ptr];
        irq      = regs[A_CTRL2][IEN_BIT] & regs[A_CTRL2][FLAG_BIT];
    end

    // Tick update first, then the bus access, so that a write overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            ptr <= '0;
        end else begin
            if (run_tick) begin
                regs[A_SEC] <= sec_wrap ? '0 : bcd_inc(regs[A_SEC]);
                if (sec_wrap) begin
                    regs[A_MIN] <= min_wrap ? '0 : bcd_inc(regs[A_MIN]);
                    if (min_wrap) regs[A_HR] <= hr_wrap ? '0 : bcd_inc(regs[A_HR]);
                end
                regs[A_CTRL2][FLAG_BIT] <= 1'b1;
            end
            if (wr_valid) begin
                if (wr_first) begin
                    ptr <= wr_data[REG_AW-1:0];
                end else begin
                    regs[ptr] <= wr_data;
                    ptr       <= ptr + 1'b1;
                end
            end else if (rd_req) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_first && ptr == '1) |=> (ptr == '0));
    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[A_CTRL1][HALT_BIT] && !wr_valid) |=> $stable(regs[A_SEC]));
    // R8
    tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && !wr_valid) |=> (regs[A_SEC] != $past(regs[A_SEC])));
endmodule

// File: rtl/rtc_i2c_top.sv
// Two-wire target RTC: line synchroniser, protocol engine and register
// file. Assumes an external open-drain pad that pulls SDA low whenever
// sda_oe is 1.
module rtc_i2c_top #(
    parameter int SYNC_STAGES = 2,
    parameter int REG_AW      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] dev_sel,
    input  logic       sec_tick,
    output logic       irq
);
    import rtc_i2c_pkg::*;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              wr_valid, wr_first, rd_req;
    logic [BYTE_W-1:0] wr_data, rd_data;

    rtc_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    rtc_bus_link u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
        .stop_ev(stop_ev), .dev_sel(dev_sel), .rd_data(rd_data),
        .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_first(wr_first),
        .wr_data(wr_data), .rd_req(rd_req)
    );

    rtc_time_regs #(.REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_first(wr_first),
        .wr_data(wr_data), .rd_req(rd_req), .sec_tick(sec_tick),
        .rd_data(rd_data), .irq(irq)
    );
endmodule

// File: tb/rtc_i2c_top_bench.sv
// Bench: a behavioural bus controller plus a register and time model.
// Read bytes and acknowledges are compared bit by bit, and irq is
// compared against the model on every clock while the bus is quiet.
module rtc_i2c_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic irq;
    logic sec_tick = 1'b0;
    logic [2:0] dev_sel = 3'b001;

    int checks = 0;
    int fails = 0;
    int mreg [16];
    bit cmp_en = 1'b0;
    bit quiet_mon = 1'b0;
    bit saw_drive = 1'b0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;

    assign sda_bus = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_i2c_top u_rtc_i2c_top (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
        .sda_oe(sda_oe), .dev_sel(dev_sel), .sec_tick(sec_tick), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_irq();
        return (mreg[1] & 1) != 0 && (mreg[1] & 2) != 0;
    endfunction

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(input int v);
        return (v >> 4) * 10 + (v & 15);
    endfunction

    // Time model built from R8..R10.
    task automatic model_tick();
        int s, m, h;
        if ((mreg[0] & 32) == 0) begin
            s = from_bcd(mreg[2]) + 1;
            m = from_bcd(mreg[3]);
            h = from_bcd(mreg[4]);
            if (s == 60) begin s = 0; m++; end
            if (m == 60) begin m = 0; h++; end
            if (h == 24) h = 0;
            mreg[2] = to_bcd(s);
            mreg[3] = to_bcd(m);
            mreg[4] = to_bcd(h);
            mreg[1] = mreg[1] | 2;
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCL period starting and ending with SCL low; returns the bus SDA.
    task automatic bus_bit(input logic b, output logic seen);
        wait_n(Q);
        sda_drv = b;
        wait_n(Q);
        scl_drv = 1'b1;
        wait_n(Q);
        seen = sda_bus;
        wait_n(Q);
        scl_drv = 1'b0;
    endtask

    task automatic bus_start();
        wait_n(Q);
        sda_drv = 1'b1;
        wait_n(Q);
        scl_drv = 1'b1;
        wait_n(2*Q);
        sda_drv = 1'b0;
        wait_n(2*Q);
        scl_drv = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(Q);
        sda_drv = 1'b0;
        wait_n(Q);
        scl_drv = 1'b1;
        wait_n(2*Q);
        sda_drv = 1'b1;
        wait_n(2*Q);
    endtask

    task automatic send_byte(input int b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, ack);
    endtask

    task automatic recv_byte(input logic nack, output int b);
        logic s;
        b = 0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            b = (b << 1) | int'(s);
        end
        bus_bit(nack, s);
    endtask

    // R2 R5 R6: write a pointer and then the given bytes.
    task automatic wr_txn(input int ptr, input int data[$]);
        logic ack;
        int p;
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hA2, ack);
        check(ack == 1'b0, "R2 write-address ack", ack, 0);
        send_byte(ptr, ack);
        check(ack == 1'b0, "R5 pointer ack", ack, 0);
        p = ptr & 15;
        foreach (data[i]) begin
            send_byte(data[i], ack);
            check(ack == 1'b0, "R5 data ack", ack, 0);
            mreg[p] = data[i];
            p = (p + 1) % 16;
        end
        bus_stop();
        wait_n(4);
        cmp_en = 1'b1;
    endtask

    // R1 R7: set the pointer, repeated START, read n bytes, NACK the last.
    task automatic rd_txn(input int ptr, input int n, input string req);
        logic ack;
        int b;
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hA2, ack);
        check(ack == 1'b0, "R2 write-address ack", ack, 0);
        send_byte(ptr, ack);
        check(ack == 1'b0, "R5 pointer ack", ack, 0);
        bus_start();
        send_byte(8'hA3, ack);
        check(ack == 1'b0, "R1 repeated-start read-address ack", ack, 0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            check(b == mreg[(ptr + i) % 16], req, b, mreg[(ptr + i) % 16]);
        end
        wait_n(2);
        check(sda_oe == 1'b0, "R7 release after NACK", sda_oe, 0);
        bus_stop();
        wait_n(4);
        cmp_en = 1'b1;
    endtask

    task automatic do_tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(posedge clk);
        model_tick();
        @(negedge clk);
        sec_tick = 1'b0;
        wait_n(3);
    endtask

    // R3: a foreign address followed by a write attempt.
    task automatic foreign_txn(input int addr_byte);
        logic ack;
        cmp_en = 1'b0;
        saw_drive = 1'b0;
        bus_start();
        quiet_mon = 1'b1;
        send_byte(addr_byte, ack);
        check(ack == 1'b1, "R3 no ack for foreign address", ack, 1);
        send_byte(8'h05, ack);
        send_byte(8'h77, ack);
        quiet_mon = 1'b0;
        check(saw_drive == 1'b0, "R3 SDA left alone", saw_drive, 0);
        bus_stop();
        wait_n(4);
        cmp_en = 1'b1;
    endtask

    // R10 irq against the model every clock; R4 drive changes only with SCL low.
    always @(negedge clk) begin
        if (rst_n && cmp_en) check(irq == model_irq(), "R10 irq model", irq, model_irq());
        if (rst_n && sda_oe !== prev_oe)
            check(!(scl_drv && prev_scl), "R4 drive change while SCL low", scl_drv, 0);
        if (quiet_mon && sda_oe) saw_drive = 1'b1;
        prev_oe = sda_oe;
        prev_scl = scl_drv;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mreg[i] = 0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        // R11
        check(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
        check(irq == 1'b0, "R11 irq low", irq, 0);
        cmp_en = 1'b1;
        // R11 R6: all zero, and a 17-byte read wraps to 00h.
        rd_txn(0, 17, "R11 R6 reset contents and read wrap");
        // R5 storage at 05h onward.
        wr_txn(5, '{8'h11, 8'h22, 8'h3C, 8'h80});
        rd_txn(5, 4, "R5 R7 stored bytes MSB first");
        // R6 write wrap 0Fh -> 00h.
        wr_txn(14, '{8'hAA, 8'h5B, 8'h00});
        rd_txn(14, 3, "R6 write wrap");
        // R3 foreign addresses: strap mismatch and prefix mismatch.
        foreign_txn(8'hA4);
        foreign_txn(8'hB2);
        rd_txn(5, 1, "R3 register untouched");
        // R8 BCD carry and full rollover.
        wr_txn(2, '{8'h09, 8'h00, 8'h00});
        do_tick();
        rd_txn(2, 1, "R8 digit carry 09->10");
        wr_txn(2, '{8'h58, 8'h59, 8'h23});
        do_tick();
        rd_txn(2, 3, "R8 23:59:59");
        do_tick();
        rd_txn(2, 3, "R8 rollover to 00:00:00");
        // R9 halt.
        wr_txn(0, '{8'h20});
        do_tick();
        do_tick();
        rd_txn(2, 3, "R9 halted time");
        wr_txn(0, '{8'h00});
        do_tick();
        rd_txn(2, 1, "R9 running again");
        // R10 interrupt enable and flag.
        wr_txn(1, '{8'h01});
        check(irq == 1'b0, "R10 enabled but no event", irq, 0);
        do_tick();
        check(irq == 1'b1, "R10 event raises irq", irq, 1);
        wr_txn(1, '{8'h01});
        check(irq == 1'b0, "R10 flag cleared", irq, 0);
        wr_txn(1, '{8'h00});
        do_tick();
        check(irq == 1'b0, "R10 disabled masks irq", irq, 0);
        rd_txn(1, 1, "R10 flag set while disabled");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule